// File: doc/BRIEF.md
# Overlay Memory Bank Mapper

This block sits beside a processor's memory bus and decides, one bus cycle at a time, whether a memory access goes to local overlay RAM or to the target system's own memory. The overlay is made of 4 KB blocks. Each block has a 4-bit placement value, which picks the 4 KB region of the 64 KB address space it covers. Blocks are grouped into banks, and each bank has an enable with three states: off, read-only and read/write. All blocks in a bank share that enable.

For each qualified cycle the mapper registers four outputs. These are an overlay chip select, a local RAM address (block index joined to the 12-bit offset), a signal that keeps the target memory from answering, and a write enable. The write enable depends on the bank mode and on who issued the access: the running target program or the emulator host. A bank that is switched off drops out of the map, but its blocks keep their local RAM slice. When the bank is turned back on, the same addresses map to the same local locations.

All outputs appear one clock after the cycle is presented. Placement and mode come in as static configuration inputs.

Top module: `ovl_bank_mapper`

## Requirements
- R1: While reset is held, and at the first sample after reset, `ovl_sel`, `tgt_suppress` and `ovl_we` are 0 and `ovl_addr` is 0. Reset is asynchronous, active low, and is released synchronously.
- R2: Block i's placement is `cfg_place[4i+3:4i]`. Placement n covers addresses n*0x1000 through n*0x1000+0xFFF. A memory cycle inside an enabled block's range drives `ovl_sel` and `tgt_suppress` to 1 one clock later. An address just outside the range drives both to 0.
- R3: On a hit, `ovl_addr` is the winning block index in the upper bits and the cycle address bits 11:0 in the lower 12 bits.
- R4: Bank j's mode is `cfg_mode[2j+1:2j]`, encoded 0 = off, 1 = read-only, 2 = read/write and 3 = off. An off bank never selects. Turning the bank back on maps the same address to the same `ovl_addr` as before.
- R5: In read-only mode, a target-program write (`cyc_host`=0) still selects the block and suppresses the target, but leaves `ovl_we` at 0. A host write (`cyc_host`=1) sets `ovl_we` to 1.
- R6: In read/write mode, a write from either source sets `ovl_we` to 1.
- R7: Blocks j*BLKS_PER_BANK through j*BLKS_PER_BANK+BLKS_PER_BANK-1 share bank j's mode.
- R8: When several enabled blocks match an address, the lowest-numbered block wins, and its mode qualifies the write.
- R9: An I/O cycle (`cyc_io`=1) never selects the overlay.
- R10: A clock with `cyc_valid`=0 drives all outputs to 0 on the next clock.
- R11: `ovl_we` is never 1 for a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_addr | input | 16 | Cycle address |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_io | input | 1 | 1 = I/O port cycle |
| cyc_host | input | 1 | 1 = cycle issued by emulator host |
| cfg_place | input | 4*NUM_BANKS*BLKS_PER_BANK | Per-block 4-bit placement |
| cfg_mode | input | 2*NUM_BANKS | Per-bank 2-bit mode |
| ovl_sel | output | 1 | Overlay RAM chip select |
| ovl_addr | output | IDX_W+12 | Overlay local address |
| tgt_suppress | output | 1 | Keep target memory from answering |
| ovl_we | output | 1 | Qualified overlay write enable |

## Verification
The harshest case comes up when priority arbitration and write qualification land in the same cycle. In that case two blocks from banks in different modes cover one 4 KB region, and a write arrives there. The bench places block 0 (read-only bank) and block 3 (read/write bank) over the same range and issues a target write. The expected result is block 0's local address, with select and suppress set and the write enable cleared. The same address issued as a host write must then raise the write enable. Once the lower bank is off, the higher block must take over.

// File: rtl/ovl_map_pkg.sv
package ovl_map_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RO   = 2'd1,
    MODE_RW   = 2'd2,
    MODE_RSVD = 2'd3
  } ovl_mode_e;

  localparam int unsigned PAGE_W = 4;
  localparam int unsigned OFS_W  = 12;

  function automatic logic mode_on(input logic [1:0] m);
    return (m == MODE_RO) || (m == MODE_RW);
  endfunction

endpackage

// File: rtl/ovl_blk_match.sv
module ovl_blk_match
  import ovl_map_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] place,
  input  logic [1:0]        mode,
  output logic              hit,
  output logic              rw_ok
);

  always_comb begin
    hit   = mode_on(mode) && (page == place);
    rw_ok = (mode == MODE_RW);
  end

endmodule

// File: rtl/ovl_prio_enc.sv
module ovl_prio_enc #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ovl_bank_mapper.sv
module ovl_bank_mapper
  import ovl_map_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned BLKS_PER_BANK = 2,
  localparam int unsigned NBLK  = NUM_BANKS * BLKS_PER_BANK,
  localparam int unsigned IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int unsigned LAW   = IDX_W + 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cyc_valid,
  input  logic [15:0]           cyc_addr,
  input  logic                  cyc_write,
  input  logic                  cyc_io,
  input  logic                  cyc_host,
  input  logic [NBLK*4-1:0]     cfg_place,
  input  logic [NUM_BANKS*2-1:0] cfg_mode,
  output logic                  ovl_sel,
  output logic [LAW-1:0]        ovl_addr,
  output logic                  tgt_suppress,
  output logic                  ovl_we
);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-block address compare
  logic [NBLK-1:0] blk_hit;
  logic [NBLK-1:0] blk_rw;
  logic            mem_cyc;

  assign mem_cyc = cyc_valid && !cyc_io;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    localparam int unsigned BANK = b / BLKS_PER_BANK;
    logic hit_raw;
    ovl_blk_match u_match (
      .page  (cyc_addr[15:12]),
      .place (cfg_place[4*b +: 4]),
      .mode  (cfg_mode[2*BANK +: 2]),
      .hit   (hit_raw),
      .rw_ok (blk_rw[b])
    );
    assign blk_hit[b] = hit_raw && mem_cyc;
  end

  logic             win_any;
  logic [IDX_W-1:0] win_idx;

  ovl_prio_enc #(.N(NBLK), .IDX_W(IDX_W)) u_prio (
    .req (blk_hit),
    .any (win_any),
    .idx (win_idx)
  );

  // next-state
  logic           sel_d, we_d;
  logic [LAW-1:0] addr_d;
  logic           upd_en;

  always_comb begin
    sel_d  = win_any;
    addr_d = win_any ? {win_idx, cyc_addr[11:0]} : '0;
    we_d   = win_any && cyc_write && (blk_rw[win_idx] || cyc_host);
    upd_en = win_any || ovl_sel || ovl_we;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ovl_sel      <= 1'b0;
      tgt_suppress <= 1'b0;
      ovl_we       <= 1'b0;
      ovl_addr     <= '0;
    end else if (upd_en) begin
      ovl_sel      <= sel_d;
      tgt_suppress <= sel_d;
      ovl_we       <= we_d;
      ovl_addr     <= addr_d;
    end
  end

endmodule

// File: rtl/ovl_bank_mapper_chk.sv
module ovl_bank_mapper_chk #(
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned BLKS_PER_BANK = 2,
  localparam int unsigned NBLK  = NUM_BANKS * BLKS_PER_BANK,
  localparam int unsigned IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int unsigned LAW   = IDX_W + 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cyc_valid,
  input logic [15:0]            cyc_addr,
  input logic                   cyc_write,
  input logic                   cyc_io,
  input logic                   cyc_host,
  input logic [NBLK*4-1:0]      cfg_place,
  input logic [NUM_BANKS*2-1:0] cfg_mode,
  input logic                   ovl_sel,
  input logic [LAW-1:0]         ovl_addr,
  input logic                   tgt_suppress,
  input logic                   ovl_we
);

  // R9
  io_never_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_io) |=> !ovl_sel);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> (!ovl_sel && !ovl_we && !tgt_suppress));

  // R11
  read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_write) |=> !ovl_we);

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_io) |=> (!ovl_sel || ovl_addr[11:0] == $past(cyc_addr[11:0])));

  // R5
  we_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_we |-> (ovl_sel && tgt_suppress));

  // R2
  sel_tracks_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_suppress == ovl_sel);

endmodule

bind ovl_bank_mapper ovl_bank_mapper_chk #(
  .NUM_BANKS(NUM_BANKS), .BLKS_PER_BANK(BLKS_PER_BANK)
) u_chk (.*);

// File: tb/ovl_bank_mapper_tb.sv
module ovl_bank_mapper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_valid, cyc_write, cyc_io, cyc_host;
  logic [15:0] cyc_addr;
  logic [15:0] cfg_place;
  logic [3:0]  cfg_mode;
  logic        ovl_sel, tgt_suppress, ovl_we;
  logic [13:0] ovl_addr;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_write(cyc_write), .cyc_io(cyc_io), .cyc_host(cyc_host),
    .cfg_place(cfg_place), .cfg_mode(cfg_mode), .ovl_sel(ovl_sel),
    .ovl_addr(ovl_addr), .tgt_suppress(tgt_suppress), .ovl_we(ovl_we)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] addr;
    logic        wr;
    logic        io;
    logic        host;
    logic        vld;
    logic        esel;
    logic [13:0] eaddr;
    logic        ewe;
  } vec_t;

  // placement: blk0=4, blk1=5, blk2=A, blk3=4 -> 16'h4A54
  // mode nibble {bank1, bank0}: 0 off, 1 RO, 2 RW, 3 off
  localparam vec_t VEC [NV] = '{
    '{4'b1010, 16'h4123, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0123, 1'b0}, // R2 R3 R8
    '{4'b1010, 16'h5FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 14'h1FFF, 1'b1}, // R6
    '{4'b1010, 16'hA000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 14'h2000, 1'b1}, // R6 host
    '{4'b1010, 16'h3FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0000, 1'b0}, // R2 edge below
    '{4'b1010, 16'h6000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0000, 1'b0}, // R2 edge above
    '{4'b1010, 16'h4FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0FFF, 1'b0}, // R2 top of range
    '{4'b1000, 16'h4010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 14'h3010, 1'b0}, // R4 R8 bank0 off
    '{4'b1000, 16'h5000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0000, 1'b0}, // R7 blk1 off too
    '{4'b1001, 16'h4010, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0010, 1'b0}, // R5 R8 RO wins
    '{4'b1001, 16'h4010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 14'h0010, 1'b1}, // R5 host write
    '{4'b1001, 16'h4010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 14'h0000, 1'b0}, // R9
    '{4'b1001, 16'h4010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000, 1'b0}, // R10
    '{4'b1111, 16'hA000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 14'h0000, 1'b0}, // R4 code 3 off
    '{4'b1010, 16'h4010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 14'h0010, 1'b0}, // R4 re-enable
    '{4'b0100, 16'hAFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 14'h2FFF, 1'b0}  // R5 R7 bank1 RO
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic es, input logic [13:0] ea,
                           input logic ew);
    check({req, " sel"}, {15'd0, ovl_sel}, {15'd0, es});
    check({req, " suppress"}, {15'd0, tgt_suppress}, {15'd0, es});
    check({req, " addr"}, {2'd0, ovl_addr}, {2'd0, ea});
    check({req, " we"}, {15'd0, ovl_we}, {15'd0, ew});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    cyc_valid = 1'b0; cyc_write = 1'b0; cyc_io = 1'b0; cyc_host = 1'b0;
    cyc_addr = 16'h0; cfg_place = 16'h4A54; cfg_mode = 4'b1010;
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 1'b0, 14'h0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R1 after reset", 1'b0, 14'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cfg_mode  = VEC[i].mode;
      cyc_addr  = VEC[i].addr;
      cyc_write = VEC[i].wr;
      cyc_io    = VEC[i].io;
      cyc_host  = VEC[i].host;
      cyc_valid = VEC[i].vld;
      @(negedge clk);
      check_out($sformatf("vec%0d", i), VEC[i].esel, VEC[i].eaddr, VEC[i].ewe);
    end

    // R8: move block 0 away, block 3 alone covers 0x4xxx in RW bank
    cfg_place = 16'h4A57; cfg_mode = 4'b1001;
    cyc_valid = 1'b1; cyc_io = 1'b0; cyc_host = 1'b0; cyc_write = 1'b1;
    cyc_addr = 16'h4ABC;
    @(negedge clk);
    check_out("R8 blk3 alone", 1'b1, 14'h3ABC, 1'b1);

    // R2: relocated block 0 at 0x7000
    cyc_addr = 16'h7000; cyc_write = 1'b0;
    @(negedge clk);
    check_out("R2 relocated", 1'b1, 14'h0000, 1'b0);

    // R1: asynchronous reset clears outputs at once
    #2 rst_n = 1'b0;
    #1;
    check_out("R1 async", 1'b0, 14'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R10 idle after reset", 1'b0, 14'h0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule